// File: doc/BRIEF.md
# Shared-Bus Word Memory Module

This block is an 8K-word by 16-bit storage module that hangs on a 16-line bus on which addresses and data take turns. The bus master first sends an address with the load-address strobe and then sends one or more read or store strobes. Three input pins, tied off by the system integrator, give the module its place in the 64K-word address space. The upper three bits of every loaded address are compared against them, and only one module on the bus claims each address.

Selection is decided once, when the address is loaded, and is then remembered. Later read and store strobes act only on that remembered selection and on the latched word address. The module never samples the ID pins for them. Any number of reads and stores may follow one address load. The module drives the bus only while a read strobe is active and it is selected. At all other times its output enable is low and its data output is zero.

Top module: `mxb_mem_module`

## Requirements
- R1: After a cycle with `rst` high, the module is unselected: with no new address load, `bus_oe` stays 0 and `bus_out` stays 0 even when `rd` is asserted.
- R2: On a clock edge with `la` high, the module latches `bus_in[12:0]` as the word address. It sets its select flag when `bus_in[15:13]` equals `mod_id[2:0]` and clears it otherwise.
- R3: On a clock edge with `sd` high, `la` low and the select flag set, `bus_in` is written into the latched word. A later read of that word returns it.
- R4: In a cycle with `rd` high, `la` and `sd` low and the select flag set, `bus_oe` is 1 and `bus_out` carries the latched word in that same cycle. No clock edge is needed.
- R5: While the select flag is clear, `rd` does not raise `bus_oe` and `sd` writes nothing. A later selected read of the same word returns its earlier contents.
- R6: The latched address and the select flag keep their values across any number of `rd` and `sd` cycles until the next `la`.
- R7: In a cycle where `la` is high, `rd` and `sd` are ignored: `bus_oe` is 0 and no word is written.
- R8: In a cycle with both `rd` and `sd` high, the store takes effect and the module does not drive the bus (`bus_oe` is 0).
- R9: Whenever `bus_oe` is 0, `bus_out` is all zeros.
- R10: `mod_id` is used only at an address load. Changing it afterwards does not change the current selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| la | input | 1 | Load-address strobe |
| rd | input | 1 | Read strobe |
| sd | input | 1 | Store strobe |
| bus_in | input | 16 | Value currently on the shared bus |
| mod_id | input | 3 | Hard-wired module window number |
| bus_out | output | 16 | Word driven toward the bus, zero when not driving |
| bus_oe | output | 1 | High while the module drives the bus |

## Verification
Stores and reads are tried at the first and last word of the window, at a middle word and at a spread of sixteen addresses. This separates correct use of the 13 address bits from truncated or shifted addressing. Loads whose upper bits do not match the ID pins, and ID pins changed after a load, tell a selection latched at load time from one that is re-evaluated on every strobe. Strobes that overlap in one cycle (load with store, load with read, read with store) expose a wrong priority among the strobes, and a second read after several strobes shows that the address and selection persist.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam int DEF_BUS_W = 16;
    localparam int DEF_ID_W  = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic la;
        logic rd;
        logic sd;
    } strobes_t;

    // Priority: address load first, then store, then read.
    function automatic bus_op_e decode_op(input strobes_t s);
        if (s.la)      return OP_LOAD;
        else if (s.sd) return OP_STORE;
        else if (s.rd) return OP_READ;
        else           return OP_IDLE;
    endfunction

endpackage

// File: rtl/mxb_strobe_dec.sv
module mxb_strobe_dec
    import mxb_pkg::*;
(
    input  strobes_t strb,
    input  logic     sel,
    output logic     load_en,
    output logic     store_en,
    output logic     read_en
);
    bus_op_e op;

    always_comb begin
        op       = decode_op(strb);
        load_en  = (op == OP_LOAD);
        store_en = (op == OP_STORE) && sel;
        read_en  = (op == OP_READ) && sel;
    end
endmodule

// File: rtl/mxb_addr_latch.sv
module mxb_addr_latch #(
    parameter int BUS_W = 16,
    parameter int ID_W  = 3,
    localparam int AW   = BUS_W - ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [ID_W-1:0]  mod_id,
    output logic [AW-1:0]    addr_q,
    output logic             sel_q
);
    logic id_hit;

    always_comb id_hit = (bus_in[BUS_W-1:AW] == mod_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
        end else if (load_en) begin
            addr_q <= bus_in[AW-1:0];
            sel_q  <= id_hit;
        end
    end
endmodule

// File: rtl/mxb_word_store.sv
module mxb_word_store #(
    parameter int AW    = 13,
    parameter int DW    = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_comb rdata = mem[addr];
endmodule

// File: rtl/mxb_mem_module.sv
module mxb_mem_module
    import mxb_pkg::*;
#(
    parameter int BUS_W = DEF_BUS_W,
    parameter int ID_W  = DEF_ID_W,
    localparam int AW   = BUS_W - ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             la,
    input  logic             rd,
    input  logic             sd,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [ID_W-1:0]  mod_id,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);
    strobes_t         strb;
    logic             load_en, store_en, read_en;
    logic [AW-1:0]    addr_q;
    logic             sel_q;
    logic [BUS_W-1:0] rdata;

    always_comb strb = '{la: la, rd: rd, sd: sd};

    mxb_strobe_dec u_dec (
        .strb     (strb),
        .sel      (sel_q),
        .load_en  (load_en),
        .store_en (store_en),
        .read_en  (read_en)
    );

    mxb_addr_latch #(.BUS_W(BUS_W), .ID_W(ID_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .bus_in  (bus_in),
        .mod_id  (mod_id),
        .addr_q  (addr_q),
        .sel_q   (sel_q)
    );

    mxb_word_store #(.AW(AW), .DW(BUS_W)) u_store (
        .clk   (clk),
        .we    (store_en),
        .addr  (addr_q),
        .wdata (bus_in),
        .rdata (rdata)
    );

    always_comb begin
        bus_oe  = read_en;
        bus_out = read_en ? rdata : '0;
    end
endmodule

// File: rtl/mxb_mem_module_chk.sv
module mxb_mem_module_chk #(
    parameter int BUS_W = 16,
    parameter int ID_W  = 3,
    localparam int AW   = BUS_W - ID_W
) (
    input logic             clk,
    input logic             rst,
    input logic             la,
    input logic             rd,
    input logic             sd,
    input logic [BUS_W-1:0] bus_in,
    input logic [ID_W-1:0]  mod_id,
    input logic [BUS_W-1:0] bus_out,
    input logic             bus_oe,
    input logic [AW-1:0]    addr_q,
    input logic             sel_q
);
    assert_reset_unsel_R1: assert property (@(posedge clk)
        rst |=> !sel_q);

    assert_select_R2: assert property (@(posedge clk) disable iff (rst)
        la |=> (sel_q == ($past(bus_in[BUS_W-1:AW]) == $past(mod_id)))
               && (addr_q == $past(bus_in[AW-1:0])));

    assert_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (rd && !sd && !la && sel_q) |-> bus_oe);

    assert_unsel_R5: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (sel_q && rd));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !la |=> ($stable(sel_q) && $stable(addr_q)));

    assert_load_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        la |-> !bus_oe);

    assert_store_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (rd && sd) |-> !bus_oe);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0));
endmodule

bind mxb_mem_module mxb_mem_module_chk #(.BUS_W(BUS_W), .ID_W(ID_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .la      (la),
    .rd      (rd),
    .sd      (sd),
    .bus_in  (bus_in),
    .mod_id  (mod_id),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .addr_q  (addr_q),
    .sel_q   (sel_q)
);

// File: tb/tb_mxb_mem_module.sv
`timescale 1ns/1ps
module tb_mxb_mem_module;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        la = 1'b0, rd = 1'b0, sd = 1'b0;
    logic [15:0] bus_in = '0;
    logic [2:0]  mod_id = 3'b101;
    logic [15:0] bus_out;
    logic        bus_oe;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int          ref_mem [int];
    int          ref_addr = 0;
    bit          ref_sel  = 0;

    always #10 clk = ~clk;

    mxb_mem_module dut (
        .clk(clk), .rst(rst), .la(la), .rd(rd), .sd(sd),
        .bus_in(bus_in), .mod_id(mod_id), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic step(input logic l, input logic r, input logic s,
                        input logic [15:0] b, input string tag);
        logic        exp_oe;
        logic [15:0] exp_out;
        bit          known;
        la = l; rd = r; sd = s; bus_in = b;
        #5;
        exp_oe  = r && !s && !l && ref_sel;
        known   = ref_mem.exists(ref_addr);
        exp_out = (exp_oe && known) ? 16'(ref_mem[ref_addr]) : 16'h0;
        checks++;
        if (bus_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: bus_oe actual %b expected %b", tag, bus_oe, exp_oe);
        end else if ((!exp_oe || known) && bus_out !== exp_out) begin
            fails++;
            $display("FAIL %s: bus_out actual %h expected %h", tag, bus_out, exp_out);
        end
        @(posedge clk);
        if (l) begin
            ref_addr = int'(b[12:0]);
            ref_sel  = (b[15:13] == mod_id);
        end else if (s && ref_sel) begin
            ref_mem[ref_addr] = int'(b);
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] a, input string tag);
        step(1'b1, 1'b0, 1'b0, a, tag);
    endtask
    task automatic store(input logic [15:0] d, input string tag);
        step(1'b0, 1'b0, 1'b1, d, tag);
    endtask
    task automatic read(input string tag);
        step(1'b0, 1'b1, 1'b0, 16'h0, tag);
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        read("R1 read after reset");
        store(16'h5555, "R1 store after reset");
        read("R9 idle output zero");

        load(16'hA123, "R2 load selected");
        store(16'hBEEF, "R3 store mid word");
        read("R4 read mid word");
        read("R6 second read same word");
        step(1'b0, 1'b0, 1'b0, 16'hFFFF, "R9 idle selected");

        load(16'hA000, "R2 load first word");
        store(16'h0F0F, "R3 store first word");
        load(16'hBFFF, "R2 load last word");
        store(16'hF00D, "R3 store last word");
        read("R4 read last word");
        load(16'hA000, "R2 reload first word");
        read("R4 read first word");

        load(16'h4123, "R5 load other window");
        store(16'h1111, "R5 store unselected");
        read("R5 read unselected");
        load(16'hA123, "R5 reselect");
        read("R5 word unchanged");

        mod_id = 3'b000;
        read("R10 id change keeps selection");
        load(16'hA123, "R10 load with new id");
        read("R10 now unselected");
        mod_id = 3'b101;

        load(16'hA042, "R7 setup");
        store(16'h4242, "R7 setup store");
        step(1'b1, 1'b0, 1'b1, 16'hA042, "R7 load with store");
        read("R7 store ignored");
        step(1'b1, 1'b1, 1'b0, 16'hA042, "R7 load with read");

        step(1'b0, 1'b1, 1'b1, 16'h7E57, "R8 read with store");
        read("R8 store took effect");

        for (int i = 0; i < 16; i++) begin
            load(16'hA000 | 16'(i * 509), "R2 sweep load");
            store(16'(i * 4099 + 3), "R3 sweep store");
            read("R6 sweep read back");
        end
        for (int i = 0; i < 16; i++) begin
            load(16'hA000 | 16'(i * 509), "R2 sweep reload");
            read("R4 sweep verify");
        end

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_sel = 0;
        ref_addr = 0;
        read("R1 read after second reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule